// File: doc/BRIEF.md
# Device Transaction Coherency Window Decoder

This block sits on the path of device-initiated memory transactions and decides, one address at a time, whether each one belongs to the hardware-coherent memory window. Transactions inside the window are flagged for the coherency path. All others are flagged as non-coherent and take the plain memory path. The block only decodes and flags. It does no snooping and no cache lookup.

Software sets up the window through a small write-only register port. It writes a base register in 4 KB units, a log-encoded size register, and a control register that holds an enable bit and a partial-coherency bit. The window must be programmed while coherency is off. Base or size writes that arrive while it is on are dropped, and a sticky error flag records the attempt. Each routing decision is registered and appears one cycle after its address.

Top module: `io_coh_aperture`

## Requirements
- R1: After reset, out_valid, out_coherent, out_partial and cfg_err are all 0, and coherency is disabled.
- R2: out_valid is high exactly one cycle after a cycle with in_valid high. out_coherent and out_partial are only ever high together with out_valid.
- R3: While the enable bit is clear, every transaction is reported with out_coherent = 0.
- R4: The window spans 2^(S+2) KB, where S is the size code. S = 0 gives 4 KB, 0x11 gives 512 MB and 0x12 gives 1 GB. It starts at the base value times 4096. With enable set, an address at or above the start and below the end gives out_coherent = 1.
- R5: With enable set, addresses below the start or at/above the end, including ones that differ only in high address bits, give out_coherent = 0.
- R6: Base bits below the window size are ignored, so a misaligned base acts as if it were rounded down to the window alignment.
- R7: A base or size write made while enable is set leaves the window unchanged and sets cfg_err. cfg_err stays set until reset, including after coherency is disabled again.
- R8: The register port selects with cfg_sel: 0 = base, 1 = size (low 5 bits), 2 = control (bit 0 enable, bit 1 partial), 3 = no register. The control register accepts writes at any time.
- R9: out_partial equals out_coherent AND the partial-coherency bit.
- R10: A size code that reaches or exceeds ADDR_W-12 makes the whole address space coherent when enabled.
- R11: A transaction presented in the same cycle as a register write is judged against the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 size, 2 control, 3 none |
| cfg_wdata | input | ADDR_W-12 | Register write data |
| in_valid | input | 1 | Transaction address valid |
| in_addr | input | ADDR_W | Transaction byte address |
| out_valid | output | 1 | Routing decision valid |
| out_coherent | output | 1 | Transaction lies in the coherent window |
| out_partial | output | 1 | Coherent transaction under partial coherency |
| cfg_err | output | 1 | Sticky flag: window write attempted while enabled |

## Verification
A register write and a transaction decode can occur in the same cycle. The bench provokes this by raising the enable bit in the same cycle as an in-window address. The decision for that address must still come out non-coherent, and an identical address one cycle later must come out coherent. A second case is a locked base write that arrives while transactions keep flowing. There, the decisions must go on following the old window while cfg_err rises.

// File: rtl/io_coh_aperture.sv
module io_coh_aperture #(
  parameter int ADDR_W = 40,
  parameter int SIZE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-13:0] cfg_wdata,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_coherent,
  output logic              out_partial,
  output logic              cfg_err
);
  localparam int PAGE_W = ADDR_W - 12;
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_SIZE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  logic [PAGE_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;
  logic              en_q, part_q;
  logic [ADDR_W-1:0] keep_mask;
  logic              hit;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      keep_mask[i] = (i >= 12 + int'(size_q));
  end

  assign hit = (((in_addr ^ {base_q, 12'h000}) & keep_mask) == '0);

  wire win_wr = cfg_we && (cfg_sel == SEL_BASE || cfg_sel == SEL_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      size_q       <= '0;
      en_q         <= 1'b0;
      part_q       <= 1'b0;
      cfg_err      <= 1'b0;
      out_valid    <= 1'b0;
      out_coherent <= 1'b0;
      out_partial  <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_coherent <= in_valid && en_q && hit;
      out_partial  <= in_valid && en_q && hit && part_q;
      if (win_wr && en_q) cfg_err <= 1'b1;
      if (cfg_we && !en_q && cfg_sel == SEL_BASE) base_q <= cfg_wdata;
      if (cfg_we && !en_q && cfg_sel == SEL_SIZE) size_q <= cfg_wdata[SIZE_W-1:0];
      if (cfg_we && cfg_sel == SEL_CTRL) begin
        en_q   <= cfg_wdata[0];
        part_q <= cfg_wdata[1];
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_coh_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_coherent |-> out_valid);
  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !out_coherent);
  p_base_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_we && cfg_sel == SEL_BASE) |=> $stable(base_q));
  p_size_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_we && cfg_sel == SEL_SIZE) |=> $stable(size_q));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  p_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_partial |-> out_coherent);
endmodule

// File: tb/io_coh_aperture_tb.sv
module io_coh_aperture_tb;
  localparam int ADDR_W = 40;
  localparam int PAGE_W = ADDR_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [PAGE_W-1:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic out_valid, out_coherent, out_partial, cfg_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  io_coh_aperture #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_coherent(out_coherent),
    .out_partial(out_partial), .cfg_err(cfg_err));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [PAGE_W-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [ADDR_W-1:0] a, logic exp_coh, logic exp_part, string req);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, out_valid, 1'b1);
    check({req, " coherent"}, out_coherent, exp_coh);
    check({req, " partial"}, out_partial, exp_part);
  endtask

  task automatic t_reset();
    check("R1 valid", out_valid, 1'b0);
    check("R1 coherent", out_coherent, 1'b0);
    check("R1 partial", out_partial, 1'b0);
    check("R1 err", cfg_err, 1'b0);
  endtask

  task automatic t_latency();
    send(40'h00_8000_0000, 1'b0, 1'b0, "R2");
    @(negedge clk);
    check("R2 idle", out_valid, 1'b0);
  endtask

  task automatic t_disabled();
    wr(2'd0, 28'h0080000);
    wr(2'd1, 28'h11);
    send(40'h00_8000_0000, 1'b0, 1'b0, "R3");
    check("R3 no err", cfg_err, 1'b0);
  endtask

  task automatic t_same_cycle();
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 28'h1;
    in_valid = 1'b1; in_addr = 40'h00_8000_0000;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R11 old enable", out_coherent, 1'b0);
    send(40'h00_8000_0000, 1'b1, 1'b0, "R11 new enable");
  endtask

  task automatic t_window();
    send(40'h00_9FFF_FFFF, 1'b1, 1'b0, "R4 last byte");
    send(40'h00_9234_5678, 1'b1, 1'b0, "R4 mid");
    send(40'h00_A000_0000, 1'b0, 1'b0, "R5 end");
    send(40'h00_7FFF_FFFF, 1'b0, 1'b0, "R5 below");
    send(40'h01_8000_0000, 1'b0, 1'b0, "R5 high bits");
  endtask

  task automatic t_partial();
    wr(2'd2, 28'h3);
    send(40'h00_8000_1000, 1'b1, 1'b1, "R9 hit");
    send(40'h00_C000_0000, 1'b0, 1'b0, "R9 miss");
    wr(2'd3, 28'h0);
    send(40'h00_8000_1000, 1'b1, 1'b1, "R8 sel3 no effect");
  endtask

  task automatic t_locked();
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 28'h0;
    in_valid = 1'b1; in_addr = 40'h00_8000_0000;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R7 flow coherent", out_coherent, 1'b1);
    check("R7 err set", cfg_err, 1'b1);
    send(40'h00_0000_1000, 1'b0, 1'b0, "R7 base kept");
    wr(2'd1, 28'h12);
    send(40'h00_A000_0000, 1'b0, 1'b0, "R7 size kept");
    wr(2'd2, 28'h0);
    check("R7 err sticky", cfg_err, 1'b1);
  endtask

  task automatic t_misaligned();
    wr(2'd0, 28'h0080123);
    wr(2'd1, 28'h11);
    wr(2'd2, 28'h1);
    send(40'h00_8000_0000, 1'b1, 1'b0, "R6 rounded start");
    send(40'h00_A000_0000, 1'b0, 1'b0, "R6 rounded end");
  endtask

  task automatic t_small();
    wr(2'd2, 28'h0);
    wr(2'd0, 28'h0012345);
    wr(2'd1, 28'h0);
    wr(2'd2, 28'h1);
    send(40'h00_1234_5000, 1'b1, 1'b0, "R4 4K start");
    send(40'h00_1234_5FFF, 1'b1, 1'b0, "R4 4K last");
    send(40'h00_1234_6000, 1'b0, 1'b0, "R5 4K end");
    send(40'h00_1234_4FFF, 1'b0, 1'b0, "R5 4K below");
  endtask

  task automatic t_saturate();
    wr(2'd2, 28'h0);
    wr(2'd1, 28'h1F);
    wr(2'd2, 28'h1);
    send(40'h00_0000_0000, 1'b1, 1'b0, "R10 low");
    send(40'hFF_FFFF_FFFF, 1'b1, 1'b0, "R10 high");
    wr(2'd2, 28'h0);
    send(40'hFF_FFFF_FFFF, 1'b0, 1'b0, "R3 disabled again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_disabled();
    t_same_cycle();
    t_window();
    t_partial();
    t_locked();
    t_misaligned();
    t_small();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule